// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Special-Value Resolver

This combinational block sits beside the arithmetic datapath of a half-precision fused multiply-add unit that computes `a*b + c`, with an optional negation of the product. It classifies the three operands and decides whether the result is a special value that can be produced without normalization, alignment, addition or rounding. These are NaN inputs, an infinity multiplied by an exact zero, infinite operands or products, and sums in which the product is an exact zero. When it has a result, it raises `bypass_vld` and drives the special result and the invalid-operation flag. The surrounding unit then selects this result instead of the rounded datapath output.

Operands use the usual half-precision layout: the sign is in bit 15, the biased exponent in bits 14:10 and the fraction in bits 9:0. The active rounding mode is an input because it decides the sign of an exactly zero sum.

Top module: `fp16_fma_special`

## Requirements
- R1: An operand whose exponent field is 0x1F and whose fraction is nonzero is a NaN. It is quiet when fraction bit 9 (word bit 9) is 1 and signaling when that bit is 0.
- R2: When any operand is a NaN, `bypass_vld` is 1 and `special_res` is the selected NaN with bit 9 forced to 1. Its sign and all other bits are kept.
- R3: Outside the infinity-times-zero case, the NaN is taken from c if c is a NaN, otherwise from b if b is a NaN, otherwise from a.
- R4: Any signaling NaN among the three operands sets `invalid`.
- R5: When one of a, b is infinite (exponent 0x1F, fraction 0) and the other is an exact zero (word bits 14:0 all 0), and c is a NaN, `invalid` is 1 and the result is c quieted.
- R6: An infinity multiplied by an exact zero with a non-NaN c gives `invalid` = 1 and `special_res` = 0x7E00.
- R7: The product sign is sign(a) XOR sign(b) XOR `neg_prod`.
- R8: When c is infinite and the product is infinite with the opposite sign, the result is 0x7E00 with `invalid` = 1. When c is infinite in any other case, the result is infinity (0x7C00 or 0xFC00) with the sign of c and `invalid` = 0.
- R9: When c is finite and the product is infinite, the result is infinity with the product sign and `invalid` = 0.
- R10: When the product is an exact zero and c is an exact zero, the result is a zero. If the two signs match, it carries that sign. Otherwise it is negative only when `rnd_mode` is 1 (round down). The other encodings are 0 = nearest even, 2 = up and 3 = toward zero.
- R11: When the product is an exact zero and c is nonzero and not NaN, the result is c unchanged, with `invalid` = 0.
- R12: When none of these cases applies, `bypass_vld`, `special_res` and `invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | Multiplicand a |
| op_b | input | 16 | Multiplier b |
| op_c | input | 16 | Addend c |
| neg_prod | input | 1 | Negate the product before the sum |
| rnd_mode | input | 2 | Rounding mode: 0 nearest even, 1 down, 2 up, 3 toward zero |
| bypass_vld | output | 1 | Result is special and replaces the datapath result |
| special_res | output | 16 | Special result, zero when bypass_vld is low |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The NaN path and the infinity-times-zero path can both be active on the same operand set. An infinite a with a zero b and a NaN c triggers both, and so does a signaling NaN in c combined with a product of infinity and zero. The bench provokes each combination with a quiet c and with a signaling c. It judges that c wins the selection and is returned quieted, and that `invalid` is raised by the infinity-times-zero condition even when c is already quiet. The product-sign logic and the infinity conflict also meet when `neg_prod` flips an opposite-signed infinite sum into a same-signed one. The bench drives that case both ways.

// File: rtl/fp16_sc_pkg.sv
package fp16_sc_pkg;

  localparam int FP_EXP_W  = 5;
  localparam int FP_FRAC_W = 10;
  localparam int FP_W      = 1 + FP_EXP_W + FP_FRAC_W;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_DOWN      = 2'd1,
    RM_UP        = 2'd2,
    RM_TO_ZERO   = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_qnan;
    logic is_snan;
    logic is_inf;
    logic is_zero;
  } op_class_t;

  // Force the quiet bit (fraction MSB) of a NaN pattern.
  function automatic logic [FP_W-1:0] make_quiet(input logic [FP_W-1:0] x);
    logic [FP_W-1:0] q;
    q = x;
    q[FP_FRAC_W-1] = 1'b1;
    return q;
  endfunction

  // Canonical quiet NaN: positive, exponent all ones, quiet bit only.
  function automatic logic [FP_W-1:0] canon_nan();
    logic [FP_W-1:0] n;
    n = '0;
    n[FP_W-2:FP_FRAC_W] = '1;
    n[FP_FRAC_W-1]      = 1'b1;
    return n;
  endfunction

  function automatic logic [FP_W-1:0] make_inf(input logic s);
    logic [FP_W-1:0] n;
    n = '0;
    n[FP_W-1]           = s;
    n[FP_W-2:FP_FRAC_W] = '1;
    return n;
  endfunction

  function automatic logic [FP_W-1:0] make_zero(input logic s);
    logic [FP_W-1:0] n;
    n = '0;
    n[FP_W-1] = s;
    return n;
  endfunction

  // Sign of an exact zero sum of two zeros.
  function automatic logic zero_sum_sign(input logic ps, input logic cs,
                                         input rnd_mode_e rm);
    if (ps == cs) return ps;
    return (rm == RM_DOWN);
  endfunction

endpackage

// File: rtl/fp16_op_class.sv
module fp16_op_class
  import fp16_sc_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output op_class_t    cls
);

  logic exp_ones;
  logic exp_zero;
  logic frac_nz;
  logic quiet_bit;

  assign exp_ones  = &op[W-2:FRAC_W];
  assign exp_zero  = ~|op[W-2:FRAC_W];
  assign frac_nz   = |op[FRAC_W-1:0];
  assign quiet_bit = op[FRAC_W-1];

  always_comb begin
    cls.sign    = op[W-1];
    cls.is_nan  = exp_ones & frac_nz;
    cls.is_qnan = exp_ones & frac_nz & quiet_bit;
    cls.is_snan = exp_ones & frac_nz & ~quiet_bit;
    cls.is_inf  = exp_ones & ~frac_nz;
    cls.is_zero = exp_zero & ~frac_nz;
  end

endmodule

// File: rtl/fp16_nan_pick.sv
module fp16_nan_pick
  import fp16_sc_pkg::*;
#(
  parameter int W = FP_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  op_class_t    cls_a,
  input  op_class_t    cls_b,
  input  op_class_t    cls_c,
  input  logic         inf_times_zero,
  output logic         any_nan,
  output logic [W-1:0] nan_res,
  output logic         nan_inv
);

  logic [W-1:0] chosen;

  assign any_nan = cls_a.is_nan | cls_b.is_nan | cls_c.is_nan;

  // Priority c > b > a; inf*zero forces c (the only possible NaN then).
  always_comb begin
    if (inf_times_zero || cls_c.is_nan) chosen = op_c;
    else if (cls_b.is_nan)              chosen = op_b;
    else                                chosen = op_a;
  end

  assign nan_res = make_quiet(chosen);
  assign nan_inv = cls_a.is_snan | cls_b.is_snan | cls_c.is_snan | inf_times_zero;

  // R3: selected source must itself be a NaN
  always_comb begin
    if (any_nan) begin
      a_r3_pick_is_nan: assert (&chosen[W-2:FP_FRAC_W] && (|chosen[FP_FRAC_W-1:0]))
        else $error("selected NaN source is not a NaN");
    end
  end

endmodule

// File: rtl/fp16_inf_zero_res.sv
module fp16_inf_zero_res
  import fp16_sc_pkg::*;
#(
  parameter int W = FP_W
) (
  input  logic [W-1:0] op_c,
  input  op_class_t    cls_a,
  input  op_class_t    cls_b,
  input  op_class_t    cls_c,
  input  logic         neg_prod,
  input  rnd_mode_e    rnd_mode,
  output logic         inf_times_zero,
  output logic         prod_sign,
  output logic         prod_inf,
  output logic         prod_zero,
  output logic         vld,
  output logic [W-1:0] res,
  output logic         inv
);

  assign inf_times_zero = (cls_a.is_inf & cls_b.is_zero) | (cls_a.is_zero & cls_b.is_inf);
  assign prod_sign      = cls_a.sign ^ cls_b.sign ^ neg_prod;
  assign prod_inf       = cls_a.is_inf | cls_b.is_inf;
  assign prod_zero      = cls_a.is_zero | cls_b.is_zero;

  always_comb begin
    vld = 1'b1;
    inv = 1'b0;
    res = '0;
    if (inf_times_zero) begin
      inv = 1'b1;
      res = canon_nan();
    end else if (cls_c.is_inf) begin
      if (prod_inf && (prod_sign != cls_c.sign)) begin
        inv = 1'b1;
        res = canon_nan();
      end else begin
        res = make_inf(cls_c.sign);
      end
    end else if (prod_inf) begin
      res = make_inf(prod_sign);
    end else if (prod_zero) begin
      if (cls_c.is_zero) res = make_zero(zero_sum_sign(prod_sign, cls_c.sign, rnd_mode));
      else               res = op_c;
    end else begin
      vld = 1'b0;
    end
  end

  // R9: finite c with infinite product keeps the product sign
  always_comb begin
    if (vld && !inf_times_zero && !cls_c.is_inf && prod_inf) begin
      a_r9_prod_inf_sign: assert (res[W-1] == prod_sign)
        else $error("infinite product result has wrong sign");
    end
  end

endmodule

// File: rtl/fp16_fma_special.sv
module fp16_fma_special
  import fp16_sc_pkg::*;
#(
  parameter int EXP_W  = FP_EXP_W,
  parameter int FRAC_W = FP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int N_OPS = 3
) (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic [15:0] op_c,
  input  logic        neg_prod,
  input  logic [1:0]  rnd_mode,
  output logic        bypass_vld,
  output logic [15:0] special_res,
  output logic        invalid
);

  logic [W-1:0] ops [N_OPS];
  op_class_t    cls [N_OPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign ops[2] = op_c;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fp16_op_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[i]),
      .cls (cls[i])
    );
  end

  // Named internal events
  logic         w_inf_times_zero;
  logic         w_prod_sign;
  logic         w_prod_inf;
  logic         w_prod_zero;
  logic         w_any_nan;
  logic         w_any_snan;
  logic [W-1:0] w_nan_res;
  logic         w_nan_inv;
  logic         w_num_vld;
  logic [W-1:0] w_num_res;
  logic         w_num_inv;

  assign w_any_snan = cls[0].is_snan | cls[1].is_snan | cls[2].is_snan;

  fp16_inf_zero_res #(.W(W)) u_num (
    .op_c           (ops[2]),
    .cls_a          (cls[0]),
    .cls_b          (cls[1]),
    .cls_c          (cls[2]),
    .neg_prod       (neg_prod),
    .rnd_mode       (rnd_mode_e'(rnd_mode)),
    .inf_times_zero (w_inf_times_zero),
    .prod_sign      (w_prod_sign),
    .prod_inf       (w_prod_inf),
    .prod_zero      (w_prod_zero),
    .vld            (w_num_vld),
    .res            (w_num_res),
    .inv            (w_num_inv)
  );

  fp16_nan_pick #(.W(W)) u_nan (
    .op_a           (ops[0]),
    .op_b           (ops[1]),
    .op_c           (ops[2]),
    .cls_a          (cls[0]),
    .cls_b          (cls[1]),
    .cls_c          (cls[2]),
    .inf_times_zero (w_inf_times_zero),
    .any_nan        (w_any_nan),
    .nan_res        (w_nan_res),
    .nan_inv        (w_nan_inv)
  );

  always_comb begin
    if (w_any_nan) begin
      bypass_vld  = 1'b1;
      special_res = w_nan_res;
      invalid     = w_nan_inv;
    end else begin
      bypass_vld  = w_num_vld;
      special_res = w_num_res;
      invalid     = w_num_inv;
    end
  end

  // Port-level checks
  always_comb begin
    if (w_any_nan) begin
      a_r2_nan_is_quiet: assert (bypass_vld && (&special_res[W-2:FRAC_W]) && special_res[FRAC_W-1])
        else $error("NaN input did not yield a quiet NaN");
    end
    if (w_any_snan) begin
      a_r4_snan_invalid: assert (invalid)
        else $error("signaling NaN did not raise invalid");
    end
    if (w_inf_times_zero) begin
      a_r6_inf_zero_invalid: assert (invalid && bypass_vld)
        else $error("inf*zero did not raise invalid");
    end
    if (!bypass_vld) begin
      a_r12_idle_zero: assert (special_res == '0 && !invalid)
        else $error("idle outputs not zero");
    end
  end

endmodule

// File: tb/test_fp16_fma_special.sv
`timescale 1ns/100ps
module test_fp16_fma_special;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a, b, c;
  logic        neg;
  logic [1:0]  rm;
  logic        vld, inv;
  logic [15:0] res;

  fp16_fma_special i_fp16_fma_special (
    .op_a(a), .op_b(b), .op_c(c), .neg_prod(neg), .rnd_mode(rm),
    .bypass_vld(vld), .special_res(res), .invalid(inv)
  );

  typedef struct {
    string       tag;
    logic [17:0] exp;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Independent model: returns {vld, inv, res}
  function automatic logic [17:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic [15:0] z, input logic n,
                                        input logic [1:0] m);
    bit xn, yn, zn, xs, ys, zs, xi, yi, zi, x0, y0, z0, iz, ps;
    xn = (x[14:10] == 5'h1F) && (x[9:0] != 0);
    yn = (y[14:10] == 5'h1F) && (y[9:0] != 0);
    zn = (z[14:10] == 5'h1F) && (z[9:0] != 0);
    xs = xn && !x[9]; ys = yn && !y[9]; zs = zn && !z[9];
    xi = (x[14:0] == 15'h7C00); yi = (y[14:0] == 15'h7C00); zi = (z[14:0] == 15'h7C00);
    x0 = (x[14:0] == 0); y0 = (y[14:0] == 0); z0 = (z[14:0] == 0);
    iz = (xi && y0) || (x0 && yi);
    ps = x[15] ^ y[15] ^ n;
    if (xn || yn || zn) begin
      if (zn || iz) return {1'b1, 1'b1 & (xs | ys | zs | iz), z | 16'h0200};
      if (yn)       return {1'b1, 1'b1 & (xs | ys | zs), y | 16'h0200};
      return {1'b1, 1'b1 & (xs | ys | zs), x | 16'h0200};
    end
    if (iz) return {2'b11, 16'h7E00};
    if (zi) begin
      if ((xi || yi) && ps != z[15]) return {2'b11, 16'h7E00};
      return {2'b10, z};
    end
    if (xi || yi) return {2'b10, ps ? 16'hFC00 : 16'h7C00};
    if (x0 || y0) begin
      if (z0) begin
        if (ps == z[15]) return {2'b10, ps, 15'h0};
        return {2'b10, (m == 2'd1), 15'h0};
      end
      return {2'b10, z};
    end
    return 18'h0;
  endfunction

  task automatic drive(input string tag, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] z, input logic n, input logic [1:0] m);
    item_t it;
    @(posedge clk);
    #1;
    a = x; b = y; c = z; neg = n; rm = m;
    it.tag = tag;
    it.exp = model(x, y, z, n, m);
    q.push_back(it);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if ({vld, inv, res} !== it.exp) begin
          bad++;
          $display("FAIL %s: got vld=%b inv=%b res=%h expected vld=%b inv=%b res=%h",
                   it.tag, vld, inv, res, it.exp[17], it.exp[16], it.exp[15:0]);
        end
      end
    end
  end

  initial begin
    a = 0; b = 0; c = 0; neg = 0; rm = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state inputs: all zero -> +0 special
    drive("R10 reset zeros", 16'h0000, 16'h0000, 16'h0000, 0, 0);
    // R10 zero sums with rounding modes
    drive("R10 +0 + -0 rne", 16'h0000, 16'h0000, 16'h8000, 0, 0);
    drive("R10 +0 + -0 down", 16'h0000, 16'h0000, 16'h8000, 0, 1);
    drive("R10 +0 + -0 up", 16'h0000, 16'h0000, 16'h8000, 0, 2);
    drive("R10 +0 + -0 rz", 16'h0000, 16'h0000, 16'h8000, 0, 3);
    drive("R10 -0 + -0", 16'h8000, 16'h0000, 16'h8000, 0, 0);
    drive("R7 neg prod zero", 16'h0000, 16'h0000, 16'h8000, 1, 0);
    drive("R7 neg flips to +", 16'h8000, 16'h0000, 16'h0000, 1, 1);
    // R1 R2 R4 NaN classes
    drive("R2 qnan a", 16'h7E01, 16'h3C00, 16'h3C00, 0, 0);
    drive("R4 snan a", 16'h7C01, 16'h3C00, 16'h3C00, 0, 0);
    drive("R1 snan low payload", 16'hFD00, 16'h3C00, 16'h3C00, 0, 0);
    drive("R3 b over a", 16'h7E05, 16'hFD00, 16'h3C00, 0, 0);
    drive("R3 c over b a", 16'h7E05, 16'h7F00, 16'h7E10, 0, 0);
    drive("R3 snan c over qnan b", 16'h3C00, 16'h7E22, 16'hFC03, 0, 0);
    // R5 R6 infinity times zero
    drive("R5 inf*0 qnan c", 16'h7C00, 16'h0000, 16'h7E33, 0, 0);
    drive("R5 inf*0 snan c", 16'h0000, 16'hFC00, 16'h7C02, 0, 0);
    drive("R6 inf*0 finite c", 16'h0000, 16'hFC00, 16'h3C00, 0, 0);
    drive("R6 inf*0 inf c", 16'h7C00, 16'h8000, 16'hFC00, 0, 0);
    // R8 c infinite
    drive("R8 inf conflict", 16'h7C00, 16'h3C00, 16'hFC00, 0, 0);
    drive("R8 inf conflict negated away", 16'h7C00, 16'h3C00, 16'hFC00, 1, 0);
    drive("R8 finite prod", 16'h3C00, 16'h3C00, 16'h7C00, 0, 0);
    drive("R8 zero prod", 16'h0000, 16'h3C00, 16'hFC00, 0, 0);
    // R9 product infinite
    drive("R9 -inf prod", 16'hFC00, 16'h4000, 16'h3C00, 0, 0);
    drive("R9 negated", 16'hFC00, 16'h4000, 16'h3C00, 1, 0);
    drive("R9 inf*subnormal", 16'h7C00, 16'h0001, 16'h0000, 0, 0);
    // R11 zero product
    drive("R11 c normal", 16'h0000, 16'h1234, 16'h5678, 0, 1);
    drive("R11 c subnormal", 16'h8000, 16'h1234, 16'h8001, 1, 0);
    // R12 no special case
    drive("R12 normals", 16'h3C00, 16'h3C00, 16'h3C00, 0, 0);
    drive("R12 subnormal prod zero c", 16'h0001, 16'h0001, 16'h0000, 0, 1);
    drive("R12 max finite", 16'h7BFF, 16'hFBFF, 16'h7BFF, 1, 2);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule